// File: doc/BRIEF.md
# Configurable Push-Down Stack Engine

This block keeps a stack pointer and a private single-port-per-direction synchronous RAM, and carries out push and pop requests against them. Two parameters pick the stack convention at build time: the direction of growth (toward higher or toward lower addresses), and what the pointer marks (the most recently written slot, or the first free slot). The convention decides whether the pointer moves before or after the RAM access of each operation. All four combinations come from the same source.

The stack's origin is taken from the `base_addr` input while reset is held. After reset the pointer rests at the empty position of the chosen convention. Each cycle the caller may raise `push_i`, with the word on `push_data`, or `pop_i`. A popped word appears on `pop_data` with `pop_valid` high on the cycle after the request, because the RAM read is registered. There is no back-pressure on either side. A request is taken or refused in the cycle it is presented, and the `pop_valid` strobe cannot be stalled. A refused request leaves the stack untouched and raises `err` for one cycle. The stack depth is a power of two, one word per slot, and the pointer steps by one word.

Top module: `stack_engine`

## Requirements
- R1: While `rst_n` is low, `base_addr` is captured. On the first cycle after reset, `sp` is the empty position, `empty`=1, `full`=0, `err`=0 and `pop_valid`=0. The empty position is base-1 (last-full, growing up), base+1 (last-full, growing down) or base (next-empty, either direction).
- R2: Each accepted push moves `sp` one word in the direction of growth. Each accepted pop moves it one word back. At all times `sp` equals the empty position offset by the number of stored words, modulo 2^ADDR_W.
- R3: Last-full convention: a push steps the pointer and then writes at the new `sp`. A pop reads at the current `sp` and then steps back.
- R4: Next-empty convention: a push writes at the current `sp` and then steps. A pop steps back first and reads at the new `sp`.
- R5: An accepted pop drives `pop_valid` high for exactly one cycle, on the cycle after the request, with the most recently pushed word still on the stack on `pop_data`.
- R6: `full` is 1 when DEPTH words are stored. A push while full is dropped: `sp` and the contents stay as they are, and `err` is 1 on the next cycle.
- R7: A pop while empty is dropped: `sp` is unchanged, `pop_valid` stays 0, and `err` is 1 on the next cycle.
- R8: `push_i` and `pop_i` high in the same cycle is refused as a whole: nothing changes and `err` is 1 on the next cycle.
- R9: `empty` is 1 exactly when no words are stored, and `full` is 1 exactly when DEPTH words are stored.
- R10: Under any interleaving of pushes and pops, the words come back in last-in, first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| base_addr | input | ADDR_W | Stack origin, captured during reset |
| push_i | input | 1 | Push request |
| push_data | input | DATA_W | Word to push |
| pop_i | input | 1 | Pop request |
| pop_data | output | DATA_W | Popped word |
| pop_valid | output | 1 | One-cycle strobe marking `pop_data` |
| sp | output | ADDR_W | Current stack pointer |
| empty | output | 1 | No words stored |
| full | output | 1 | DEPTH words stored |
| err | output | 1 | One-cycle pulse after a refused request |

## Verification
The assertions check on every cycle that the pointer stays locked to the stored-word count. They also check that each RAM write or read address sits on the correct side of the pointer update for the built convention, and that a refused request leaves the count frozen while raising the error pulse. Whether the data returned is really the right word in last-in, first-out order can only be shown by the bench scenarios. The same goes for how the pointer lands after a second reset with a different origin near address zero. The bench shows both by running all four conventions side by side against one queue model through fill, overflow, drain, underflow and a long mixed sequence.

// File: rtl/stack_pkg.sv
package stack_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_BAD  = 2'd3
  } stk_op_e;
endpackage

// File: rtl/stack_ctrl.sv
module stack_ctrl
  import stack_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  output stk_op_e          op_o,
  output logic [CNT_W-1:0] count_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [CNT_W-1:0] count_q;

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CNT_MAX);
  assign count_o = count_q;

  // Decode one request per cycle; refused requests become OP_BAD.
  always_comb begin
    op_o = OP_IDLE;
    if (push_i && pop_i)             op_o = OP_BAD;
    else if (push_i && !full_o)      op_o = OP_PUSH;
    else if (push_i)                 op_o = OP_BAD;
    else if (pop_i && !empty_o)      op_o = OP_POP;
    else if (pop_i)                  op_o = OP_BAD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= (op_o == OP_BAD);
      case (op_o)
        OP_PUSH: count_q <= count_q + 1'b1;
        OP_POP:  count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_MAX);
  assert_full_push_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && full_o) |=> (err_o && $stable(count_q)));
  assert_empty_pop_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && empty_o) |=> (err_o && $stable(count_q)));
  assert_both_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> (err_o && $stable(count_q)));
endmodule

// File: rtl/stack_ptr.sv
module stack_ptr
  import stack_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DEPTH      = 8,
  parameter bit GROW_UP    = 1'b1,
  parameter bit NEXT_EMPTY = 1'b0,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_i,
  input  stk_op_e           op_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [ADDR_W-1:0] sp_o,
  output logic              we_o,
  output logic [IDX_W-1:0]  widx_o,
  output logic              re_o,
  output logic [IDX_W-1:0]  ridx_o
);
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] sp_q;
  logic [ADDR_W-1:0] sp_fwd;
  logic [ADDR_W-1:0] sp_back;
  logic [ADDR_W-1:0] waddr;
  logic [ADDR_W-1:0] raddr;
  logic [ADDR_W-1:0] empty_pos;

  function automatic logic [ADDR_W-1:0] step_fwd(input logic [ADDR_W-1:0] a);
    return GROW_UP ? a + 1'b1 : a - 1'b1;
  endfunction

  function automatic logic [ADDR_W-1:0] step_back(input logic [ADDR_W-1:0] a);
    return GROW_UP ? a - 1'b1 : a + 1'b1;
  endfunction

  function automatic logic [ADDR_W-1:0] rest_pos(input logic [ADDR_W-1:0] b);
    return NEXT_EMPTY ? b : step_back(b);
  endfunction

  assign sp_fwd    = step_fwd(sp_q);
  assign sp_back   = step_back(sp_q);
  assign empty_pos = rest_pos(base_q);

  // The convention picks which side of the pointer update the access uses.
  generate
    if (NEXT_EMPTY) begin : g_next_empty
      assign waddr = sp_q;
      assign raddr = sp_back;
    end else begin : g_last_full
      assign waddr = sp_fwd;
      assign raddr = sp_q;
    end
  endgenerate

  assign we_o   = (op_i == OP_PUSH);
  assign re_o   = (op_i == OP_POP);
  assign widx_o = waddr[IDX_W-1:0];
  assign ridx_o = raddr[IDX_W-1:0];
  assign sp_o   = sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= base_i;
      sp_q   <= rest_pos(base_i);
    end else begin
      case (op_i)
        OP_PUSH: sp_q <= sp_fwd;
        OP_POP:  sp_q <= sp_back;
        default: sp_q <= sp_q;
      endcase
    end
  end

  assert_sp_tracks_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q == (GROW_UP ? empty_pos + ADDR_W'(count_i) : empty_pos - ADDR_W'(count_i)));

  generate
    if (NEXT_EMPTY) begin : g_chk_ne
      assert_ne_push_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |=> (sp_q == step_fwd($past(waddr))));
      assert_ne_pop_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        re_o |=> (sp_q == $past(raddr)));
    end else begin : g_chk_lf
      assert_lf_push_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |=> (sp_q == $past(waddr)));
      assert_lf_pop_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        re_o |=> (sp_q == step_back($past(raddr))));
    end
  endgenerate
endmodule

// File: rtl/stack_ram.sv
module stack_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[widx_i] <= wdata_i;
    if (re_i) rdata_o <= mem[ridx_i];
  end
endmodule

// File: rtl/stack_engine.sv
module stack_engine
  import stack_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 8,
  parameter int DEPTH      = 8,
  parameter bit GROW_UP    = 1'b1,
  parameter bit NEXT_EMPTY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_i,
  output logic [DATA_W-1:0] pop_data,
  output logic              pop_valid,
  output logic [ADDR_W-1:0] sp,
  output logic              empty,
  output logic              full,
  output logic              err
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  stk_op_e          op;
  logic [CNT_W-1:0] count;
  logic             we;
  logic             re;
  logic [IDX_W-1:0] widx;
  logic [IDX_W-1:0] ridx;

  stack_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .op_o(op), .count_o(count), .empty_o(empty), .full_o(full), .err_o(err)
  );

  stack_ptr #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .GROW_UP(GROW_UP), .NEXT_EMPTY(NEXT_EMPTY)
  ) u_ptr (
    .clk(clk), .rst_n(rst_n), .base_i(base_addr), .op_i(op), .count_i(count),
    .sp_o(sp), .we_o(we), .widx_o(widx), .re_o(re), .ridx_o(ridx)
  );

  stack_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we_i(we), .widx_i(widx), .wdata_i(push_data),
    .re_i(re), .ridx_i(ridx), .rdata_o(pop_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pop_valid <= 1'b0;
    else        pop_valid <= re;
  end

  assert_pop_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> (sp == (GROW_UP ? $past(sp) - 1'b1 : $past(sp) + 1'b1)));
  assert_refused_holds_sp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> ($stable(sp) && !pop_valid));
endmodule

// File: tb/stack_engine_tb.sv
`timescale 1ns/1ps
module stack_engine_tb;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic push_i = 1'b0;
  logic pop_i = 1'b0;
  logic [DW-1:0] push_data = '0;

  logic [DW-1:0] pd_w [4];
  logic          pv_w [4];
  logic [AW-1:0] sp_w [4];
  logic          em_w [4];
  logic          fu_w [4];
  logic          er_w [4];

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int q[$];
  int base_m;

  always #2 clk = ~clk;

  // Index bit0: grows up; bit1: next-empty pointer.
  for (genvar g = 0; g < 4; g++) begin : g_conv
    stack_engine #(
      .DATA_W(DW), .ADDR_W(AW), .DEPTH(DEPTH),
      .GROW_UP(g[0]), .NEXT_EMPTY(g[1])
    ) u_dut (
      .clk(clk), .rst_n(rst_n), .base_addr(base_addr),
      .push_i(push_i), .push_data(push_data), .pop_i(pop_i),
      .pop_data(pd_w[g]), .pop_valid(pv_w[g]), .sp(sp_w[g]),
      .empty(em_w[g]), .full(fu_w[g]), .err(er_w[g])
    );
  end

  function automatic int exp_sp(int c, int n);
    int up = c & 1;
    int ne = (c >> 1) & 1;
    int rest = ne ? base_m : (up ? base_m - 1 : base_m + 1);
    return (up ? rest + n : rest - n) & 8'hFF;
  endfunction

  task automatic chk(string tag, int c, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s conv%0d got=%0h exp=%0h", tag, c, got, exp);
    end
  endtask

  task automatic do_reset(int b);
    @(negedge clk);
    rst_n = 1'b0; base_addr = AW'(b); push_i = 0; pop_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    base_m = b;
    q.delete();
    // R1: state right after reset, before any request edge
    for (int c = 0; c < 4; c++) begin
      chk("R1 sp", c, sp_w[c], exp_sp(c, 0));
      chk("R1 empty", c, em_w[c], 1);
      chk("R1 full", c, fu_w[c], 0);
      chk("R1 err", c, er_w[c], 0);
      chk("R1 valid", c, pv_w[c], 0);
    end
  endtask

  // Called at a falling edge; drives, waits one rising edge, checks.
  task automatic step(bit ps, bit pp, int d, string ptag);
    int ev = 0, ed = 0, ee = 0;
    string etag;
    push_i = ps; pop_i = pp; push_data = DW'(d);
    etag = "R6";
    if (ps && pp) begin ee = 1; etag = "R8"; end
    else if (ps && q.size() == DEPTH) begin ee = 1; etag = "R6"; end
    else if (ps) q.push_back(d & 16'hFFFF);
    else if (pp && q.size() == 0) begin ee = 1; etag = "R7"; end
    else if (pp) begin ev = 1; ed = q.pop_back(); end
    @(posedge clk);
    @(negedge clk);
    push_i = 0; pop_i = 0;
    for (int c = 0; c < 4; c++) begin
      chk("R2 sp", c, sp_w[c], exp_sp(c, q.size()));
      chk("R9 empty", c, em_w[c], int'(q.size() == 0));
      chk("R9 full", c, fu_w[c], int'(q.size() == DEPTH));
      chk({etag, " err"}, c, er_w[c], ee);
      chk("R5 valid", c, pv_w[c], ev);
      if (ev) begin
        if (ptag.len() != 0) chk({ptag, " data"}, c, pd_w[c], ed);
        else chk(((c >> 1) & 1) ? "R4 data" : "R3 data", c, pd_w[c], ed);
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit [15:0] lf;
    do_reset(8'h40);
    step(0, 1, 0, "");                 // R7 pop on empty
    for (int i = 0; i < DEPTH; i++) step(1, 0, 16'hA000 + i, "");
    step(1, 0, 16'hDEAD, "");          // R6 push on full
    step(1, 0, 16'hBEEF, "");          // R6 again, back to back
    step(1, 1, 16'h1234, "");          // R8 both
    for (int i = 0; i < 3; i++) step(0, 1, 0, "R5");
    step(1, 0, 16'h5555, "");
    step(0, 1, 0, "");
    for (int i = 0; i < 5; i++) step(0, 1, 0, "");
    step(0, 1, 0, "");                 // R7 after drain
    // R10: long mixed sequence
    lf = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      int sel;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      sel = lf[2:0];
      if (sel < 4)      step(1, 0, lf ^ 16'h5A5A, "R10");
      else if (sel < 7) step(0, 1, 0, "R10");
      else              step(1, 1, lf, "R10");
    end
    // R1 with an origin near zero, then wrap-around pointers
    do_reset(8'h03);
    for (int i = 0; i < DEPTH; i++) step(1, 0, 16'h0C00 + i, "");
    for (int i = 0; i < DEPTH; i++) step(0, 1, 0, "");
    step(0, 1, 0, "");
    finish_run();
  end
endmodule